// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

A register-mapped bank of general-purpose lines (up to 32) with per-line direction, output value, blink and input inversion, plus interrupt generation. Every input pin passes a two-flop synchronizer. The synchronized level is then XORed with a polarity bit, and the result is the line's data-in value. That value feeds two interrupt paths.

The level path is the data-in value gated by a level mask and is never stored. The edge path latches each rising transition of data-in into a sticky cause bit, which software acknowledges by writing zeros. Each line's two paths are ORed together. The per-line results are then merged eight lines at a time into four interrupt outputs. When a second CPU is configured, that CPU has its own edge and level masks and its own four interrupt outputs, and both CPUs share the same data-in and edge cause state.

Registers are accessed on a plain single-cycle bus. A write takes effect at the clock edge where `we_i` is high. Reads return data combinationally from `addr_i`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, all interrupt outputs are 0, `pin_out_o` is 0 and every `pin_oe_o` bit is 1, because direction 0 means output.
- R2: Register offsets: 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C input polarity, 0x10 data-in (read-only, writes ignored), 0x14 edge cause, 0x18 CPU0 edge mask, 0x1C CPU0 level mask, 0x30 CPU1 edge mask, 0x34 CPU1 level mask. Any other offset reads 0.
- R3: A direction bit of 1 makes the line an input (`pin_oe_o` bit 0). A direction bit of 0 drives `pin_out_o` from the output value bit, unless blink is enabled for that line.
- R4: A data-in bit reads as pin XOR polarity. A pin change is visible there after the second rising clock edge.
- R5: The level cause of a line is data-in AND level mask, with no storage. The interrupt drops again once the adjusted input goes low.
- R6: A 0-to-1 change of a data-in bit sets its edge cause bit at the next clock edge, including a change caused by a polarity write. The bit stays set until it is cleared.
- R7: Writing the edge cause register clears each bit written 0 and leaves each bit written 1 unchanged.
- R8: An edge that arrives in the same cycle as a clearing write leaves its cause bit set.
- R9: Interrupt output g of a CPU is the OR, over lines 8g to 8g+7, of (data-in AND level mask) OR (edge cause AND edge mask).
- R10: The CPU1 masks at 0x30/0x34 drive `irq_cpu1_o` independently of the CPU0 masks, using the same causes.
- R11: A line with its blink bit set toggles `pin_out_o` every BLINK_HALF cycles. Lines with blink clear hold their output value.
- R12: Bits at or above NUM_LINES ignore writes, read 0, and ignore their pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pin_in_i | input | NUM_LINES | Asynchronous pin levels |
| pin_out_o | output | NUM_LINES | Pin drive value |
| pin_oe_o | output | NUM_LINES | Pin drive enable (1 = driven) |
| irq_cpu0_o | output | 4 | CPU0 grouped interrupts |
| irq_cpu1_o | output | 4 | CPU1 grouped interrupts (0 without second CPU) |

## Verification
The bench builds the bank with NUM_LINES = 28, DUAL_CPU = 1 and BLINK_HALF = 4.

With 28 lines, the top group is only half populated, so the masking of unimplemented bits in writes, reads and pins can be observed at the ports. The second CPU is enabled so that two independent mask sets can be compared against shared causes. A blink half-period of four cycles lets the bench count toggles within a short window.

Random pin, polarity, mask and acknowledge traffic runs against a model of the causes. Directed cases cover clear-versus-edge collisions and level interrupts falling away.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned MAX_LINES = 32;
  localparam int unsigned GRP_LINES = 8;
  localparam int unsigned NUM_GRPS  = MAX_LINES / GRP_LINES;

  localparam logic [7:0] OFS_OUT    = 8'h00;
  localparam logic [7:0] OFS_DIR    = 8'h04;
  localparam logic [7:0] OFS_BLINK  = 8'h08;
  localparam logic [7:0] OFS_POL    = 8'h0C;
  localparam logic [7:0] OFS_DIN    = 8'h10;
  localparam logic [7:0] OFS_ECAUSE = 8'h14;
  localparam logic [7:0] OFS_EMASK0 = 8'h18;
  localparam logic [7:0] OFS_LMASK0 = 8'h1C;
  localparam logic [7:0] OFS_EMASK1 = 8'h30;
  localparam logic [7:0] OFS_LMASK1 = 8'h34;

  typedef struct packed {
    logic [MAX_LINES-1:0] emask;
    logic [MAX_LINES-1:0] lmask;
  } mask_pair_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= 2'b00;
      else         ff_q <= {ff_q[0], async_i[i]};
    end
    assign sync_o[i] = ff_q[1];
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter bit          DUAL_CPU  = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic                 we_i,
  input  logic [MAX_LINES-1:0] wdata_i,
  input  logic [MAX_LINES-1:0] din_i,
  input  logic [MAX_LINES-1:0] ecause_i,
  output logic [MAX_LINES-1:0] rdata_o,
  output logic [MAX_LINES-1:0] out_o,
  output logic [MAX_LINES-1:0] dir_o,
  output logic [MAX_LINES-1:0] blink_o,
  output logic [MAX_LINES-1:0] pol_o,
  output mask_pair_t           masks_o [2],
  output logic                 ecause_we_o
);
  localparam logic [MAX_LINES-1:0] LINE_MASK = MAX_LINES'((64'd1 << NUM_LINES) - 64'd1);

  logic [MAX_LINES-1:0] out_q, dir_q, blink_q, pol_q;
  mask_pair_t           mask_q [2];
  logic [MAX_LINES-1:0] wd;

  assign wd = wdata_i & LINE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      blink_q <= '0;
      pol_q   <= '0;
      mask_q[0] <= '0;
      mask_q[1] <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_OUT:    out_q   <= wd;
        OFS_DIR:    dir_q   <= wd;
        OFS_BLINK:  blink_q <= wd;
        OFS_POL:    pol_q   <= wd;
        OFS_EMASK0: mask_q[0].emask <= wd;
        OFS_LMASK0: mask_q[0].lmask <= wd;
        OFS_EMASK1: if (DUAL_CPU) mask_q[1].emask <= wd;
        OFS_LMASK1: if (DUAL_CPU) mask_q[1].lmask <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFS_OUT:    rdata_o = out_q;
      OFS_DIR:    rdata_o = dir_q;
      OFS_BLINK:  rdata_o = blink_q;
      OFS_POL:    rdata_o = pol_q;
      OFS_DIN:    rdata_o = din_i;
      OFS_ECAUSE: rdata_o = ecause_i;
      OFS_EMASK0: rdata_o = mask_q[0].emask;
      OFS_LMASK0: rdata_o = mask_q[0].lmask;
      OFS_EMASK1: rdata_o = mask_q[1].emask;
      OFS_LMASK1: rdata_o = mask_q[1].lmask;
      default:    rdata_o = '0;
    endcase
  end

  assign out_o       = out_q;
  assign dir_o       = dir_q;
  assign blink_o     = blink_q;
  assign pol_o       = pol_q;
  assign masks_o     = mask_q;
  assign ecause_we_o = we_i && (addr_i == OFS_ECAUSE);

  // R12
  unimpl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_q | dir_q | blink_q | pol_q | mask_q[0].emask | mask_q[0].lmask
      | mask_q[1].emask | mask_q[1].lmask) & ~LINE_MASK) == '0);
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] prev_q, cause_q, rise, kept;

  assign rise = din_i & ~prev_q;
  assign kept = clr_we_i ? (cause_q & clr_data_i) : cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= din_i;
      cause_q <= kept | rise;  // new edge beats clear
    end
  end

  assign cause_o = cause_q;

  // R6
  edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((cause_q & $past(rise)) == $past(rise)));
  // R7
  ack_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((cause_q & $past(cause_q & clr_data_i)) == $past(cause_q & clr_data_i)));
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
  import gpio_irq_pkg::*;
(
  input  logic [MAX_LINES-1:0] din_i,
  input  logic [MAX_LINES-1:0] ecause_i,
  input  mask_pair_t           mask_i,
  output logic [NUM_GRPS-1:0]  irq_o
);
  logic [MAX_LINES-1:0] line_cause;
  assign line_cause = (din_i & mask_i.lmask) | (ecause_i & mask_i.emask);

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    assign irq_o[g] = |line_cause[g*GRP_LINES +: GRP_LINES];
  end
endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
  parameter int unsigned BLINK_HALF = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int unsigned CW = $clog2(BLINK_HALF);
  localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter bit          DUAL_CPU   = 1'b1,
  parameter int unsigned BLINK_HALF = 25_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic                 we_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] pin_in_i,
  output logic [NUM_LINES-1:0] pin_out_o,
  output logic [NUM_LINES-1:0] pin_oe_o,
  output logic [3:0]           irq_cpu0_o,
  output logic [3:0]           irq_cpu1_o
);
  localparam logic [MAX_LINES-1:0] LINE_MASK = MAX_LINES'((64'd1 << NUM_LINES) - 64'd1);

  logic [MAX_LINES-1:0] pin_sync, din, ecause;
  logic [MAX_LINES-1:0] out_q, dir_q, blink_q, pol_q, pin_out_full;
  mask_pair_t           masks [2];
  logic                 ecause_we, blink_phase;

  gpio_in_sync #(.W(MAX_LINES)) u_sync (
    .clk_i, .rst_ni,
    .async_i (MAX_LINES'(pin_in_i)),
    .sync_o  (pin_sync)
  );

  assign din = (pin_sync & LINE_MASK) ^ pol_q;

  gpio_ctrl_regs #(.NUM_LINES(NUM_LINES), .DUAL_CPU(DUAL_CPU)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i,
    .wdata_i     (wdata_i),
    .din_i       (din),
    .ecause_i    (ecause),
    .rdata_o     (rdata_o),
    .out_o       (out_q),
    .dir_o       (dir_q),
    .blink_o     (blink_q),
    .pol_o       (pol_q),
    .masks_o     (masks),
    .ecause_we_o (ecause_we)
  );

  gpio_edge_cause #(.W(MAX_LINES)) u_edge (
    .clk_i, .rst_ni,
    .din_i      (din),
    .clr_we_i   (ecause_we),
    .clr_data_i (wdata_i),
    .cause_o    (ecause)
  );

  gpio_blink_div #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk_i, .rst_ni, .phase_o (blink_phase)
  );

  for (genvar i = 0; i < MAX_LINES; i++) begin : g_pin
    assign pin_out_full[i] = blink_q[i] ? blink_phase : out_q[i];
  end

  assign pin_out_o = pin_out_full[NUM_LINES-1:0];
  assign pin_oe_o  = ~dir_q[NUM_LINES-1:0];

  gpio_irq_merge u_merge0 (
    .din_i (din), .ecause_i (ecause), .mask_i (masks[0]), .irq_o (irq_cpu0_o)
  );

  if (DUAL_CPU) begin : g_cpu1
    gpio_irq_merge u_merge1 (
      .din_i (din), .ecause_i (ecause), .mask_i (masks[1]), .irq_o (irq_cpu1_o)
    );
  end else begin : g_no_cpu1
    assign irq_cpu1_o = '0;
  end

  // R9
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_cpu0_o) |-> ((masks[0].lmask | masks[0].emask) != '0));
  // R11
  steady_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> (((pin_out_full ^ $past(pin_out_full)) & ~blink_q) == '0));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int unsigned NL = 28;
  localparam logic [31:0] LM = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NL-1:0] pins = '0;
  logic [NL-1:0] pout, poe;
  logic [3:0]  irq0, irq1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_pol = '0, m_em0 = '0, m_lm0 = '0, m_em1 = '0, m_lm1 = '0;
  logic [31:0] m_ec = '0, m_pins = '0, m_prev = '0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NUM_LINES(NL), .DUAL_CPU(1'b1), .BLINK_HALF(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_in_i(pins), .pin_out_o(pout), .pin_oe_o(poe),
    .irq_cpu0_o(irq0), .irq_cpu1_o(irq1)
  );

  function automatic logic [3:0] grp(input logic [31:0] c);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |c[g*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] din_exp();
    return (m_pins & LM) ^ m_pol;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    logic [31:0] dn;
    idle(4);
    dn = din_exp();
    m_ec = m_ec | (dn & ~m_prev);
    m_prev = dn;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(8'h10, v); chk({tag, " R4 din"}, v, din_exp());
    rd(8'h14, v); chk({tag, " R6 ecause"}, v, m_ec);
    chk({tag, " R9 irq0"}, {28'd0, irq0}, {28'd0, grp((din_exp() & m_lm0) | (m_ec & m_em0))});
    chk({tag, " R10 irq1"}, {28'd0, irq1}, {28'd0, grp((din_exp() & m_lm1) | (m_ec & m_em1))});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int tog;
    logic last;
    void'($urandom(32'h5eed_0001));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 14; a++) begin
      rd(8'(a * 4), v); chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 irq0", {28'd0, irq0}, 32'h0);
    chk("R1 irq1", {28'd0, irq1}, 32'h0);
    chk("R1 oe", 32'(poe), 32'(LM));
    chk("R1 pout", 32'(pout), 32'h0);

    // R2 / R12 map and line limit
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R12 out width", v, LM);
    wr(8'h00, 32'h0000_0008);
    wr(8'h04, 32'hF000_00F0); rd(8'h04, v); chk("R2 dir", v, 32'h0000_00F0);
    chk("R3 oe", 32'(poe), LM & ~32'h0000_00F0);
    chk("R3 pout follows out", 32'(pout), 32'h0000_0008);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R2 din write ignored", v, 32'h0);
    wr(8'h20, 32'h1234_5678); rd(8'h20, v); chk("R2 unmapped", v, 32'h0);
    wr(8'h30, 32'h0000_0100); rd(8'h30, v); chk("R2 emask1", v, 32'h0000_0100);
    wr(8'h30, 32'h0);

    // R12 pins above NL ignored: drive all implemented high via wide value
    pins = '1; m_pins = 32'hFFFF_FFFF; settle();
    rd(8'h10, v); chk("R12 din upper bits zero", v, LM);
    rd(8'h14, v); chk("R6 edges all lines", v, LM);
    wr(8'h14, 32'h0); m_ec = '0;
    pins = '0; m_pins = '0; settle();
    check_all("R7 cleared");

    // R5 level fall-away
    wr(8'h1C, 32'h0000_0200); m_lm0 = 32'h0000_0200;
    pins = NL'(32'h200); m_pins = 32'h200; settle();
    chk("R5 level high", {28'd0, irq0}, 32'h2);
    pins = '0; m_pins = '0; settle();
    chk("R5 level falls", {28'd0, irq0}, 32'h0);
    wr(8'h14, 32'h0); m_ec = '0;
    wr(8'h1C, 32'h0); m_lm0 = '0;

    // R8 edge collides with clear write
    pins = NL'(32'h40); m_pins = 32'h40; settle();   // line 6 cause set
    @(negedge clk); pins = NL'(32'h60); m_pins = 32'h60;
    idle(2);
    addr = 8'h14; wdata = 32'h0; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(8'h14, v); chk("R8 edge wins over clear", v, 32'h20);
    m_ec = 32'h20; m_prev = din_exp();
    wr(8'h14, 32'h0); m_ec = '0;
    pins = '0; m_pins = '0; settle();

    // R6 polarity write produces an edge
    wr(8'h0C, 32'h0100_0000); m_pol = 32'h0100_0000; settle();
    check_all("R6 pol edge");
    wr(8'h14, 32'hFFFF_FFFF);
    check_all("R7 ones keep");

    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [31:0] r;
      int op;
      r = $urandom();
      op = $urandom_range(0, 6);
      case (op)
        0, 1: begin pins = NL'(r); m_pins = r; settle(); end
        2: begin wr(8'h0C, r); m_pol = r & LM; settle(); end
        3: begin wr(8'h18, r); m_em0 = r & LM; wr(8'h1C, ~r); m_lm0 = ~r & LM; settle(); end
        4: begin wr(8'h30, r); m_em1 = r & LM; wr(8'h34, r >> 3); m_lm1 = (r >> 3) & LM; settle(); end
        default: begin wr(8'h14, r); m_ec = m_ec & r; settle(); end
      endcase
      check_all("rand");
    end

    // R11 blink
    wr(8'h04, 32'h0); wr(8'h00, 32'h0000_0008); wr(8'h08, 32'h0000_0004);
    tog = 0; last = pout[2];
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (pout[2] != last) tog++;
      last = pout[2];
      if (pout[3] !== 1'b1) chk("R11 non-blink line steady", 32'(pout[3]), 32'h1);
    end
    chk("R11 blink toggles", 32'((tog >= 3) && (tog <= 4)), 32'h1);
    chk("R11 out line held", 32'(pout[3]), 32'h1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule